// File: doc/BRIEF.md
# SDRAM Self-Refresh and Deep Power-Down Controller

This block sits in front of the dynamic-memory side of a memory controller and handles its low-power states. Software drives two level bits: one asks for self-refresh and one asks for deep power-down. The block reports completed self-refresh entry on an acknowledge bit that software polls. It does not drive memory pins itself. It hands abstract commands (auto-refresh, self-refresh entry, self-refresh exit, power-down, initialise) to a downstream command sequencer over a valid/ready pair. Each command is held until the sequencer accepts it.

Bus transactions come in with a flag that says whether they target dynamic or static memory. Static transactions always pass through. Dynamic transactions pass through only while the channel is in normal operation. At every other time they are answered at once with an error, so the bus never stalls.

Entry to self-refresh waits for any in-flight dynamic access to finish, then issues one auto-refresh and then the entry command. On exit the block issues the exit command and then waits a programmable number of cycles before it reopens dynamic traffic. Leaving deep power-down needs an explicit initialisation request once the deep bit is cleared.

Top module: `dram_lowpower_ctrl`

## Requirements
- R1: After reset, `sr_ack` is 0, `cmd_valid` is 0, `cmd_code` is 0, and dynamic transactions are forwarded.
- R2: Commands are coded on `cmd_code` as 1 auto-refresh, 2 self-refresh entry, 3 self-refresh exit, 4 power-down and 5 initialise, with 0 when idle. Once raised, `cmd_valid` and `cmd_code` stay unchanged until a cycle in which `cmd_ready` is 1. Self-refresh entry issues command 1 first and then command 2.
- R3: After a low-power request is taken, no command is issued while `dyn_busy` is 1. The first command appears in the cycle after a clock edge that sees `dyn_busy` at 0.
- R4: `sr_ack` rises in the cycle right after command 2 is accepted, and at no other time.
- R5: From the cycle after a low-power request is taken in normal operation until normal operation resumes, a dynamic transaction (`bus_valid`=1, `bus_dyn`=1) gives `bus_err`=1 and `dyn_fwd`=0. In normal operation it gives `dyn_fwd`=1 and `bus_err`=0.
- R6: A static transaction (`bus_valid`=1, `bus_dyn`=0) always gives `stat_fwd`=1 and `bus_err`=0, in every state.
- R7: Clearing `sr_req` while in self-refresh issues command 3. After command 3 is accepted, `sr_ack` stays 1 for exactly `exit_delay` more cycles. It then falls, and dynamic forwarding reopens in the same cycle.
- R8: If `sr_req` is cleared before entry completes, the entry still finishes. `sr_ack` is then 1 for at least one cycle, and command 3 follows without a new request.
- R9: Setting `deep_req` in normal operation drains, issues command 4 without any auto-refresh, and then holds dynamic transactions in error. `sr_ack` stays 0 throughout.
- R10: In deep power-down, `init_req` is ignored while `deep_req` is 1. With `deep_req` at 0, an `init_req` pulse issues command 5. Dynamic forwarding reopens in the cycle after command 5 is accepted.
- R11: When `deep_req` and `sr_req` are both 1 in normal operation, the deep power-down path is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sr_req | input | 1 | Self-refresh request level from the control register |
| deep_req | input | 1 | Deep power-down request level from the control register |
| init_req | input | 1 | Pulse asking for reinitialisation after deep power-down |
| exit_delay | input | DLY_W | Cycles to wait after the exit command before reopening |
| dyn_busy | input | 1 | A dynamic access is still in flight |
| cmd_ready | input | 1 | Sequencer accepts the presented command |
| cmd_valid | output | 1 | A command is presented to the sequencer |
| cmd_code | output | 3 | Command code (see R2) |
| sr_ack | output | 1 | Self-refresh acknowledge status bit |
| bus_valid | input | 1 | A bus transaction is presented |
| bus_dyn | input | 1 | 1 = dynamic-memory target, 0 = static |
| dyn_fwd | output | 1 | Transaction forwarded to the dynamic path |
| stat_fwd | output | 1 | Transaction forwarded to the static path |
| bus_err | output | 1 | Transaction completed with an error response |

## Verification
The assertions assume three things about the neighbours. First, `dyn_busy` only rises through a forwarded dynamic access, so it never rises once forwarding is closed. Second, `exit_delay` is held steady while an exit is in progress. Third, the sequencer may stall `cmd_ready` for any number of cycles. The stimulus follows these rules. It raises `dyn_busy` only in normal operation and lowers it after a few cycles. It changes `exit_delay` only between scenarios. It switches `cmd_ready` between always-ready and a one-in-three pattern. Bus traffic alternates static and dynamic targets on every cycle, so both forwarding paths are exercised in each state.

// File: rtl/dram_lp_pkg.sv
// Shared types for the dynamic-memory low-power controller.
// Assumes: nothing; holds types only.
package dram_lp_pkg;
    typedef enum logic [3:0] {
        PS_NORMAL, PS_DRAIN, PS_AREF, PS_ENTER, PS_SELFREF,
        PS_EXIT_CMD, PS_EXIT_WAIT, PS_PDOWN, PS_DEEP, PS_INIT
    } pwr_state_t;

    typedef enum logic [2:0] {
        CMD_NONE     = 3'd0,
        CMD_AUTOREF  = 3'd1,
        CMD_SR_ENTER = 3'd2,
        CMD_SR_EXIT  = 3'd3,
        CMD_PDOWN    = 3'd4,
        CMD_INIT     = 3'd5
    } lp_cmd_t;
endpackage

// File: rtl/dram_pwr_fsm.sv
// Power-state sequencer: walks the channel through drain, refresh, entry,
// self-refresh, exit and its delay, and the deep power-down path.
// Assumes: exit_delay is held steady during an exit; dyn_busy does not rise
// once dynamic forwarding is closed.
module dram_pwr_fsm
    import dram_lp_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sr_req,
    input  logic             deep_req,
    input  logic             init_req,
    input  logic             dyn_busy,
    input  logic             cmd_ready,
    input  logic [DLY_W-1:0] exit_delay,
    output pwr_state_t       state
);
    localparam logic [DLY_W-1:0] CNT_ONE = {{(DLY_W-1){1'b0}}, 1'b1};

    pwr_state_t       nxt;
    logic             to_deep, to_deep_nxt;
    logic [DLY_W-1:0] wait_cnt, wait_cnt_nxt;

    // Next-state decision for every power state.
    always_comb begin
        nxt          = state;
        to_deep_nxt  = to_deep;
        wait_cnt_nxt = wait_cnt;
        unique case (state)
            PS_NORMAL: begin
                if (deep_req) begin
                    nxt = PS_DRAIN;
                    to_deep_nxt = 1'b1;
                end else if (sr_req) begin
                    nxt = PS_DRAIN;
                    to_deep_nxt = 1'b0;
                end
            end
            PS_DRAIN:     if (!dyn_busy) nxt = to_deep ? PS_PDOWN : PS_AREF;
            PS_AREF:      if (cmd_ready) nxt = PS_ENTER;
            PS_ENTER:     if (cmd_ready) nxt = PS_SELFREF;
            PS_SELFREF:   if (!sr_req) nxt = PS_EXIT_CMD;
            PS_EXIT_CMD: begin
                if (cmd_ready) begin
                    if (exit_delay == '0) begin
                        nxt = PS_NORMAL;
                    end else begin
                        nxt = PS_EXIT_WAIT;
                        wait_cnt_nxt = CNT_ONE;
                    end
                end
            end
            PS_EXIT_WAIT: begin
                if (wait_cnt >= exit_delay) nxt = PS_NORMAL;
                else wait_cnt_nxt = wait_cnt + CNT_ONE;
            end
            PS_PDOWN:     if (cmd_ready) nxt = PS_DEEP;
            PS_DEEP:      if (!deep_req && init_req) nxt = PS_INIT;
            PS_INIT:      if (cmd_ready) nxt = PS_NORMAL;
            default:      nxt = PS_NORMAL;
        endcase
    end

    // State, target and delay-counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PS_NORMAL;
            to_deep  <= 1'b0;
            wait_cnt <= '0;
        end else begin
            state    <= nxt;
            to_deep  <= to_deep_nxt;
            wait_cnt <= wait_cnt_nxt;
        end
    end

    assert_drain_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_DRAIN && dyn_busy) |=> (state == PS_DRAIN));

    assert_wait_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_EXIT_WAIT) |-> (wait_cnt != '0 && wait_cnt <= exit_delay));
endmodule

// File: rtl/dram_cmd_issue.sv
// Command and status decode: turns the power state into the sequencer
// command, the acknowledge bit and the dynamic-forwarding permission.
// Assumes: state comes straight from a register, so all outputs are glitch-free.
module dram_cmd_issue
    import dram_lp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  pwr_state_t state,
    input  logic       cmd_ready,
    output logic       cmd_valid,
    output logic [2:0] cmd_code,
    output logic       sr_ack,
    output logic       dyn_open
);
    // Map each state to the command it presents.
    always_comb begin
        unique case (state)
            PS_AREF:     cmd_code = CMD_AUTOREF;
            PS_ENTER:    cmd_code = CMD_SR_ENTER;
            PS_EXIT_CMD: cmd_code = CMD_SR_EXIT;
            PS_PDOWN:    cmd_code = CMD_PDOWN;
            PS_INIT:     cmd_code = CMD_INIT;
            default:     cmd_code = CMD_NONE;
        endcase
    end

    // Status and gate permission.
    always_comb begin
        cmd_valid = (cmd_code != CMD_NONE);
        sr_ack    = (state == PS_SELFREF) || (state == PS_EXIT_CMD) ||
                    (state == PS_EXIT_WAIT);
        dyn_open  = (state == PS_NORMAL);
    end

    assert_cmd_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_code)));
endmodule

// File: rtl/dram_access_gate.sv
// Bus routing: sends static traffic through untouched, forwards dynamic
// traffic only when permitted and otherwise answers it with an error.
// Assumes: dyn_open is registered upstream; responses are same-cycle.
module dram_access_gate (
    input  logic bus_valid,
    input  logic bus_dyn,
    input  logic dyn_open,
    output logic dyn_fwd,
    output logic stat_fwd,
    output logic bus_err
);
    // Route one transaction per cycle.
    always_comb begin
        stat_fwd = bus_valid && !bus_dyn;
        dyn_fwd  = bus_valid && bus_dyn && dyn_open;
        bus_err  = bus_valid && bus_dyn && !dyn_open;
    end
endmodule

// File: rtl/dram_lowpower_ctrl.sv
// Top of the dynamic-memory low-power controller: sequencer FSM, command
// decode and bus gate.
// Assumes: control bits are synchronous to clk; the sequencer holds no command
// queue of its own.
module dram_lowpower_ctrl
    import dram_lp_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sr_req,
    input  logic             deep_req,
    input  logic             init_req,
    input  logic [DLY_W-1:0] exit_delay,
    input  logic             dyn_busy,
    input  logic             cmd_ready,
    output logic             cmd_valid,
    output logic [2:0]       cmd_code,
    output logic             sr_ack,
    input  logic             bus_valid,
    input  logic             bus_dyn,
    output logic             dyn_fwd,
    output logic             stat_fwd,
    output logic             bus_err
);
    pwr_state_t state;
    logic       dyn_open;

    dram_pwr_fsm #(.DLY_W(DLY_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .deep_req(deep_req),
        .init_req(init_req), .dyn_busy(dyn_busy), .cmd_ready(cmd_ready),
        .exit_delay(exit_delay), .state(state)
    );

    dram_cmd_issue u_issue (
        .clk(clk), .rst_n(rst_n), .state(state), .cmd_ready(cmd_ready),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .sr_ack(sr_ack),
        .dyn_open(dyn_open)
    );

    dram_access_gate u_gate (
        .bus_valid(bus_valid), .bus_dyn(bus_dyn), .dyn_open(dyn_open),
        .dyn_fwd(dyn_fwd), .stat_fwd(stat_fwd), .bus_err(bus_err)
    );

    assert_ack_after_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr_ack) |-> $past(cmd_valid && cmd_code == 3'd2 && cmd_ready));

    assert_dyn_rejected_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_ack && bus_valid && bus_dyn) |-> (bus_err && !dyn_fwd));

    assert_static_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_dyn) |-> (stat_fwd && !bus_err && !dyn_fwd));

    assert_ack_min_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr_ack) |=> sr_ack);
endmodule

// File: tb/dram_lowpower_ctrl_bench.sv
module dram_lowpower_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sr_req = 1'b0, deep_req = 1'b0, init_req = 1'b0;
    logic [7:0] exit_delay = 8'd3;
    logic       dyn_busy = 1'b0, cmd_ready = 1'b0;
    logic       bus_valid = 1'b0, bus_dyn = 1'b0;
    logic       cmd_valid, sr_ack, dyn_fwd, stat_fwd, bus_err;
    logic [2:0] cmd_code;

    int nchk = 0, nerr = 0, tick = 0, rdy_mode = 0;
    int mph = 0, mcnt = 0;
    bit mdeep = 0;
    bit saw_aref = 0, saw_dpd = 0, saw_init = 0, saw_exit = 0;
    bit last_ack = 0;

    always #10 clk = ~clk;

    dram_lowpower_ctrl u_dram_lowpower_ctrl (
        .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .deep_req(deep_req),
        .init_req(init_req), .exit_delay(exit_delay), .dyn_busy(dyn_busy),
        .cmd_ready(cmd_ready), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .sr_ack(sr_ack), .bus_valid(bus_valid), .bus_dyn(bus_dyn),
        .dyn_fwd(dyn_fwd), .stat_fwd(stat_fwd), .bus_err(bus_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    // Phases: 0 normal,1 drain,2 aref,3 enter,4 selfref,5 exit cmd,
    // 6 exit wait,7 power-down,8 deep,9 init.
    function automatic int exp_code(input int ph);
        case (ph)
            2: return 1;
            3: return 2;
            5: return 3;
            7: return 4;
            9: return 5;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(input int ph);
        case (ph)
            1: return "R3";
            2, 3: return "R2";
            5, 6: return "R7";
            7, 8: return "R9";
            9: return "R10";
            default: return "R5";
        endcase
    endfunction

    // One clock: drive pattern inputs, compare against model, advance model.
    task automatic cyc();
        int ec, eack;
        bit eerr, efwd, esf;
        @(negedge clk);
        tick++;
        bus_valid = (tick % 4) != 3;
        bus_dyn   = (tick % 2) == 1;
        cmd_ready = (rdy_mode == 0) ? 1'b1 : ((tick % 3) == 2);
        #1;
        ec   = exp_code(mph);
        eack = (mph >= 4 && mph <= 6) ? 1 : 0;
        eerr = bus_valid && bus_dyn && (mph != 0);
        efwd = bus_valid && bus_dyn && (mph == 0);
        esf  = bus_valid && !bus_dyn;
        if (rst_n) begin
            chk(cmd_code == ec[2:0] && cmd_valid == (ec != 0), tag_of(mph),
                int'(cmd_code), ec);
            chk(sr_ack == eack[0], (mph == 4) ? "R4" : "R7", int'(sr_ack), eack);
            chk(bus_err == eerr && dyn_fwd == efwd, "R5",
                int'({bus_err, dyn_fwd}), int'({eerr, efwd}));
            chk(stat_fwd == esf && !(stat_fwd && bus_err), "R6",
                int'(stat_fwd), int'(esf));
        end
        if (cmd_valid && cmd_code == 3'd1) saw_aref = 1;
        if (cmd_valid && cmd_code == 3'd4) saw_dpd = 1;
        if (cmd_valid && cmd_code == 3'd5) saw_init = 1;
        if (cmd_valid && cmd_code == 3'd3) saw_exit = 1;
        last_ack = sr_ack;
        @(posedge clk);
        #1;
        if (!rst_n) begin
            mph = 0; mdeep = 0; mcnt = 0;
        end else begin
            case (mph)
                0: if (deep_req) begin mph = 1; mdeep = 1; end
                   else if (sr_req) begin mph = 1; mdeep = 0; end
                1: if (!dyn_busy) mph = mdeep ? 7 : 2;
                2: if (cmd_ready) mph = 3;
                3: if (cmd_ready) mph = 4;
                4: if (!sr_req) mph = 5;
                5: if (cmd_ready) begin
                       if (exit_delay == 0) mph = 0;
                       else begin mph = 6; mcnt = 1; end
                   end
                6: if (mcnt >= int'(exit_delay)) mph = 0; else mcnt++;
                7: if (cmd_ready) mph = 8;
                8: if (!deep_req && init_req) mph = 9;
                9: if (cmd_ready) mph = 0;
                default: mph = 0;
            endcase
        end
        if (tick > 20000) begin
            chk(0, "watchdog", tick, 20000);
            finish_run();
        end
    endtask

    task automatic run_to(input int ph, input int limit);
        for (int i = 0; i < limit && mph != ph; i++) cyc();
        chk(mph == ph, "R2 progress", mph, ph);
    endtask

    initial begin
        int n;
        repeat (3) cyc();
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!sr_ack && !cmd_valid && cmd_code == 3'd0, "R1", int'(cmd_code), 0);
        bus_valid = 1'b1; bus_dyn = 1'b1; #1;
        chk(dyn_fwd && !bus_err, "R1", int'(dyn_fwd), 1);
        repeat (4) cyc();

        // Entry with a busy drain, then exit with delay 3.
        dyn_busy = 1'b1; sr_req = 1'b1; saw_aref = 0;
        repeat (4) cyc();
        chk(mph == 1 && !cmd_valid, "R3", int'(cmd_valid), 0);
        dyn_busy = 1'b0;
        run_to(4, 50);
        chk(saw_aref, "R2", saw_aref, 1);
        repeat (5) cyc();
        sr_req = 1'b0; n = 0;
        do begin cyc(); if (last_ack) n++; end while (last_ack && n < 100);
        chk(n == 2 + 3, "R7", n, 5);
        chk(mph == 0, "R7", mph, 0);
        repeat (3) cyc();

        // Exit delay 0 with a slow sequencer.
        rdy_mode = 1; exit_delay = 8'd0; sr_req = 1'b1;
        run_to(4, 60);
        repeat (2) cyc();
        sr_req = 1'b0;
        run_to(0, 60);
        repeat (3) cyc();

        // Abort during entry.
        exit_delay = 8'd2; sr_req = 1'b1; saw_exit = 0; n = 0;
        repeat (2) cyc();
        sr_req = 1'b0;
        for (int i = 0; i < 80 && !(mph == 0 && saw_exit); i++) begin
            cyc();
            if (last_ack) n++;
        end
        chk(n >= 1, "R8", n, 1);
        chk(saw_exit && mph == 0, "R8", mph, 0);
        repeat (3) cyc();

        // Deep power-down, ignored init, then proper init.
        rdy_mode = 0; saw_aref = 0; saw_dpd = 0; saw_init = 0;
        dyn_busy = 1'b1; deep_req = 1'b1;
        repeat (3) cyc();
        dyn_busy = 1'b0;
        run_to(8, 40);
        chk(saw_dpd && !saw_aref, "R9", int'(saw_aref), 0);
        init_req = 1'b1; cyc(); init_req = 1'b0;
        repeat (3) cyc();
        chk(mph == 8 && !saw_init, "R10", int'(saw_init), 0);
        deep_req = 1'b0; repeat (2) cyc();
        chk(mph == 8, "R10", mph, 8);
        init_req = 1'b1; cyc(); init_req = 1'b0;
        run_to(0, 40);
        chk(saw_init, "R10", int'(saw_init), 1);
        repeat (3) cyc();

        // Both requests at once: deep wins.
        saw_aref = 0; saw_dpd = 0;
        deep_req = 1'b1; sr_req = 1'b1;
        run_to(8, 40);
        chk(saw_dpd && !saw_aref, "R11", int'(saw_aref), 0);
        sr_req = 1'b0; deep_req = 1'b0;
        init_req = 1'b1; cyc(); init_req = 1'b0;
        run_to(0, 40);
        repeat (4) cyc();
        finish_run();
    end
endmodule